// File: doc/BRIEF.md
# Multi-Mode PWM Channel Timing Unit

This block drives one PWM channel, a complementary pair of high-side and low-side outputs, from its own symmetric period timer. The timer runs through signed values from minus half the period up to one below plus half the period, then wraps. Two signed edge values, a dead-time count and a 2-bit pulse mode decide when the high side is on. The mode confines switching to the whole period, a window centred on the middle of the period, the first half only or the second half only. Edges that fall outside the allowed region are clipped to it. A window that comes out empty or negative gives 0% duty.

The edge values, dead time and mode are captured only at the period boundary, so software may change them at any time without causing glitches. Each rising edge on either output is held back by the dead time, so the two outputs are never high together. Once per period the block also reports whether the new settings put the channel in full-on, full-off or normal modulation.

Top module: `pwm_chan_timer`

## Requirements
- R1: The timer output `count` steps by one each clock from -HALF to HALF-1, then wraps to -HALF. HALF is 20 by default, which gives a 40-clock period.
- R2: Inputs `edgeA`, `edgeB`, `deadTime` and `pulseMode` are sampled only on the clock edge where `count` wraps from HALF-1 to -HALF. Changes at any other time have no effect on the outputs until the next wrap.
- R3: Mode 00 (full period): the raw on-window is `edgeA <= count < edgeB`, within the region [-HALF, HALF).
- R4: Mode 01 (centred): the raw on-window is `-edgeB <= count < edgeB`, within the region [-HALF, HALF). `edgeA` is ignored.
- R5: Mode 10 confines the window `edgeA <= count < edgeB` to the first half, [-HALF, 0). Mode 11 confines it to the second half, [0, HALF). The high side never asserts outside that half.
- R6: Window bounds are clipped to the mode's region. If the clipped upper bound does not exceed the lower bound, the window is empty and the high side stays low for the whole period.
- R7: The low side's raw value is the complement of the high side's raw window. Each output goes high only after its raw value has been high for `deadTime` consecutive clocks, counting across period boundaries. Each output follows its raw value low at once.
- R8: `highOut` and `lowOut` are never high in the same cycle.
- R9: `modStatus` changes only at the wrap. It reports the values loaded at that wrap, with this encoding: 10 full-off when the clipped on-span is no greater than `deadTime`; otherwise 01 full-on when the window covers the whole region; otherwise 00 normal. The code 11 never appears.
- R10: During and right after reset, `count` is -HALF, the window is empty with zero dead time in mode 00, `highOut` is 0, `lowOut` is 1 and `modStatus` is 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| edgeA | input | CNT_W (signed) | Lower edge (assert point) |
| edgeB | input | CNT_W (signed) | Upper edge (deassert point) |
| deadTime | input | DT_W | Rising-edge delay in clocks |
| pulseMode | input | 2 | Pulse mode select |
| count | output | CNT_W (signed) | Current timer value |
| highOut | output | 1 | High-side drive |
| lowOut | output | 1 | Low-side drive |
| modStatus | output | 2 | Modulation status for the current period |

## Verification
The assertions assume that the edge inputs stay within the signed range of CNT_W bits and that `deadTime` fits its field. Every stimulus pattern uses values in those ranges. Clipping is exercised by edges beyond ±HALF but well inside the word, so nothing wraps around. The stimulus holds each setting for several periods and also changes inputs in the middle of a period, so the boundary capture is tested. Dead-time values cover zero, small spans, and spans longer than the window, which must yield full-off.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  typedef enum logic [1:0] {
    MODE_FULL   = 2'b00,
    MODE_CENTER = 2'b01,
    MODE_FIRST  = 2'b10,
    MODE_SECOND = 2'b11
  } pulse_mode_e;

  typedef enum logic [1:0] {
    ST_NORMAL   = 2'b00,
    ST_FULL_ON  = 2'b01,
    ST_FULL_OFF = 2'b10
  } mod_status_e;

  typedef struct packed {
    logic periodEnd;    // last count of the period; shadow load happens on this edge
    logic periodStart;  // first count of the period
  } ctrl_strobe_t;

endpackage

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int HALF  = 20
) (
  input  logic                    clk,
  input  logic                    rstN,
  output logic signed [CNT_W-1:0] count,
  output ctrl_strobe_t            strb
);

  localparam logic signed [CNT_W-1:0] CNT_MAX = CNT_W'(HALF - 1);
  localparam logic signed [CNT_W-1:0] CNT_MIN = -CNT_W'(HALF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= CNT_MIN;
    end else if (strb.periodEnd) begin
      count <= CNT_MIN;
    end else begin
      count <= count + 1'b1;
    end
  end

  always_comb begin
    strb.periodEnd   = (count == CNT_MAX);
    strb.periodStart = (count == CNT_MIN);
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (count >= CNT_MIN) && (count <= CNT_MAX)) else $error("count out of range"); // R1

  AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_MAX) |=> (count == CNT_MIN)) else $error("wrap missed"); // R1

endmodule

// File: rtl/pwm_chan_dp.sv
module pwm_chan_dp
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4,
  parameter int HALF  = 20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrl_strobe_t            strb,
  input  logic signed [CNT_W-1:0] count,
  input  logic signed [CNT_W-1:0] edgeA,
  input  logic signed [CNT_W-1:0] edgeB,
  input  logic [DT_W-1:0]         deadTime,
  input  logic [1:0]              pulseMode,
  output logic                    highOut,
  output logic                    lowOut,
  output logic [1:0]              modStatus
);

  localparam int W = CNT_W + 2;
  localparam logic signed [W-1:0] POS_HALF = W'(HALF);
  localparam logic signed [W-1:0] NEG_HALF = -W'(HALF);
  localparam logic signed [W-1:0] ZERO     = '0;
  localparam logic [DT_W-1:0]     RUN_MAX  = '1;

  // candidate window computed from the live inputs, used only at load
  logic signed [W-1:0] inA, inB, regLo, regHi, candLo, candHi, clipLo, clipHi, span, dtExt;
  mod_status_e         nextStatus;

  // active (period-stable) configuration
  logic signed [W-1:0] actLo, actHi;
  logic [DT_W-1:0]     actDt;
  pulse_mode_e         actMode;
  mod_status_e         status;

  logic signed [W-1:0] cntExt;
  logic                rawHi, rawLo;
  logic [DT_W-1:0]     hiRun, loRun;

  always_comb begin
    inA    = {{2{edgeA[CNT_W-1]}}, edgeA};
    inB    = {{2{edgeB[CNT_W-1]}}, edgeB};
    dtExt  = {{(W-DT_W){1'b0}}, deadTime};
    regLo  = NEG_HALF;
    regHi  = POS_HALF;
    candLo = inA;
    candHi = inB;
    case (pulse_mode_e'(pulseMode))
      MODE_CENTER: begin candLo = -inB; candHi = inB; end
      MODE_FIRST:  regHi = ZERO;
      MODE_SECOND: regLo = ZERO;
      default: ;
    endcase
    clipLo = (candLo > regLo) ? candLo : regLo;
    clipHi = (candHi < regHi) ? candHi : regHi;
    if (clipHi < clipLo) clipHi = clipLo;   // negative on-time becomes zero
    span = clipHi - clipLo;
    if (span <= dtExt)                           nextStatus = ST_FULL_OFF;
    else if (clipLo == regLo && clipHi == regHi) nextStatus = ST_FULL_ON;
    else                                         nextStatus = ST_NORMAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actLo   <= ZERO;
      actHi   <= ZERO;
      actDt   <= '0;
      actMode <= MODE_FULL;
      status  <= ST_FULL_OFF;
    end else if (strb.periodEnd) begin
      actLo   <= clipLo;
      actHi   <= clipHi;
      actDt   <= deadTime;
      actMode <= pulse_mode_e'(pulseMode);
      status  <= nextStatus;
    end
  end

  // raw window and dead-time run counters
  always_comb begin
    cntExt = {{2{count[CNT_W-1]}}, count};
    rawHi  = (cntExt >= actLo) && (cntExt < actHi);
    rawLo  = !rawHi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun <= '0;
      loRun <= '0;
    end else begin
      hiRun <= !rawHi ? '0 : (hiRun == RUN_MAX ? RUN_MAX : hiRun + 1'b1);
      loRun <= !rawLo ? '0 : (loRun == RUN_MAX ? RUN_MAX : loRun + 1'b1);
    end
  end

  always_comb begin
    highOut   = rawHi && (hiRun >= actDt);
    lowOut    = rawLo && (loRun >= actDt);
    modStatus = status;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(highOut && lowOut)) else $error("both sides high"); // R8

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.periodEnd |=> ($stable(actLo) && $stable(actHi) && $stable(actDt) && $stable(actMode)))
    else $error("config changed mid-period"); // R2

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.periodEnd |=> $stable(modStatus)) else $error("status changed mid-period"); // R9

  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    modStatus != 2'b11) else $error("illegal status code"); // R9

  AST_FIRST_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (actMode == MODE_FIRST && highOut) |-> (count < 0)) else $error("mode 10 leak"); // R5

  AST_SECOND_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (actMode == MODE_SECOND && highOut) |-> (count >= 0)) else $error("mode 11 leak"); // R5

  AST_DT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(highOut) && actDt != 0) |-> $past(rawHi)) else $error("dead time skipped"); // R7

endmodule

// File: rtl/pwm_chan_timer.sv
module pwm_chan_timer
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4,
  parameter int HALF  = 20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [CNT_W-1:0] edgeA,
  input  logic signed [CNT_W-1:0] edgeB,
  input  logic [DT_W-1:0]         deadTime,
  input  logic [1:0]              pulseMode,
  output logic signed [CNT_W-1:0] count,
  output logic                    highOut,
  output logic                    lowOut,
  output logic [1:0]              modStatus
);

  ctrl_strobe_t strb;

  pwm_chan_ctrl #(.CNT_W(CNT_W), .HALF(HALF)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .count (count),
    .strb  (strb)
  );

  pwm_chan_dp #(.CNT_W(CNT_W), .DT_W(DT_W), .HALF(HALF)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .count     (count),
    .edgeA     (edgeA),
    .edgeB     (edgeB),
    .deadTime  (deadTime),
    .pulseMode (pulseMode),
    .highOut   (highOut),
    .lowOut    (lowOut),
    .modStatus (modStatus)
  );

endmodule

// File: tb/tb_pwm_chan_timer.sv
module tb_pwm_chan_timer;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int DT_W  = 4;
  localparam int HALF  = 20;
  localparam int RUN_SAT = (1 << DT_W) - 1;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic signed [CNT_W-1:0] edgeA = '0;
  logic signed [CNT_W-1:0] edgeB = '0;
  logic [DT_W-1:0]         deadTime = '0;
  logic [1:0]              pulseMode = '0;
  logic signed [CNT_W-1:0] count;
  logic                    highOut, lowOut;
  logic [1:0]              modStatus;

  int    nChecks = 0;
  int    nFails  = 0;
  string curReq  = "R3";
  bit    finished = 0;

  // reference model state
  int mCount, mLo, mHi, mDt, mMode, mSt, rH, rL;

  pwm_chan_timer #(.CNT_W(CNT_W), .DT_W(DT_W), .HALF(HALF)) dut (
    .clk(clk), .rstN(rstN), .edgeA(edgeA), .edgeB(edgeB),
    .deadTime(deadTime), .pulseMode(pulseMode), .count(count),
    .highOut(highOut), .lowOut(lowOut), .modStatus(modStatus)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction
  function automatic int imin(int a, int b); return (a < b) ? a : b; endfunction

  task automatic loadModel();
    int a, b, lo, hi, rlo, rhi;
    a = int'(edgeA); b = int'(edgeB);
    rlo = -HALF; rhi = HALF; lo = a; hi = b;
    if (pulseMode == 2'b01) begin lo = -b; hi = b; end
    if (pulseMode == 2'b10) rhi = 0;
    if (pulseMode == 2'b11) rlo = 0;
    lo = imax(lo, rlo);
    hi = imin(hi, rhi);
    if (hi < lo) hi = lo;
    mLo = lo; mHi = hi; mDt = int'(deadTime); mMode = int'(pulseMode);
    if (hi - lo <= mDt)             mSt = 2;
    else if (lo == rlo && hi == rhi) mSt = 1;
    else                             mSt = 0;
  endtask

  function automatic bit rawH(); return (mCount >= mLo) && (mCount < mHi); endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCount = -HALF; mLo = 0; mHi = 0; mDt = 0; mMode = 0; mSt = 2; rH = 0; rL = 0;
    end else begin
      bit r;
      r = rawH();
      rH = r ? imin(rH + 1, RUN_SAT) : 0;
      rL = !r ? imin(rL + 1, RUN_SAT) : 0;
      if (mCount == HALF - 1) begin
        loadModel();
        mCount = -HALF;
      end else begin
        mCount++;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at count %0d", req, what, act, exp, mCount);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      bit r, eh, el;
      r  = rawH();
      eh = r && (rH >= mDt);
      el = !r && (rL >= mDt);
      if (!rstN) begin
        check("R10", "reset count", int'(count), -HALF);
        check("R10", "reset high", int'(highOut), 0);
        check("R10", "reset low", int'(lowOut), 1);
        check("R10", "reset status", int'(modStatus), 2);
      end else begin
        check("R1", "count", int'(count), mCount);
        check(curReq, "highOut", int'(highOut), int'(eh));
        check("R7", "lowOut", int'(lowOut), int'(el));
        check("R9", "status", int'(modStatus), mSt);
        check("R8", "overlap", int'(highOut && lowOut), 0);
      end
    end
  end

  task automatic apply(int a, int b, int dt, int mode, int periods, string req);
    @(negedge clk);
    curReq = req;
    edgeA = CNT_W'(a); edgeB = CNT_W'(b);
    deadTime = DT_W'(dt); pulseMode = 2'(mode);
    repeat (periods * 2 * HALF) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    apply(-5, 8, 0, 0, 3, "R3");      // normal, mode 00
    apply(-30, 30, 0, 0, 3, "R6");    // clipped to full-on
    apply(6, -4, 0, 0, 2, "R6");      // inverted window -> 0%
    apply(-8, 8, 3, 0, 3, "R7");      // dead time on both sides
    apply(99, 7, 2, 1, 3, "R4");      // centred, edgeA ignored
    apply(0, 25, 0, 1, 2, "R4");      // centred full-on
    apply(-12, -3, 1, 2, 3, "R5");    // first half normal
    apply(-40, 40, 0, 2, 3, "R5");    // first half full-on clipped
    apply(3, 15, 2, 3, 3, "R5");      // second half normal
    apply(-40, 40, 4, 3, 3, "R5");    // second half full-on
    apply(-2, 4, 9, 0, 2, "R9");      // dead time exceeds span -> full-off
    apply(-19, 19, 15, 0, 2, "R7");   // long dead time
    // mid-period changes must not take effect before the wrap
    @(negedge clk);
    curReq = "R2";
    repeat (7) @(negedge clk);
    edgeA = -3; edgeB = 3; deadTime = 1; pulseMode = 2'b00;
    repeat (11) @(negedge clk);
    edgeA = -15; edgeB = 10; pulseMode = 2'b10;
    repeat (3 * 2 * HALF) @(negedge clk);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule